// File: doc/BRIEF.md
# Indirect-Access Redirection Register File

This block is a register file holding the interrupt redirection table. Software reaches it through a 32-bit memory-mapped window with two locations. A select location holds an 8-bit pointer. A data location reads or writes whichever internal register that pointer names. Behind the window are four kinds of register:

- an identification register;
- a fixed version word;
- an arbitration word that always reads zero;
- a bank of redirection entries, each 64 bits wide. Each entry is reached as a low half and a high half at two consecutive select values.

Every entry is also presented in parallel on a wide output bus to the delivery engine that sits next to this block. Each entry write also produces a one-cycle strobe, which tells that engine to make a fresh service pass over the table. Reads are combinational from the stored state. Writes take effect on the rising clock edge at which the write strobe is high.

Top module: `ioredir_regfile`

## Requirements
- R1: Only address bits 7:0 are decoded. Address bits above bit 7 have no effect, so offset 0x310 behaves exactly like offset 0x10.
- R2: Offset 0x00 is the select register. A write stores wdata[7:0], and a read returns the stored value zero-extended to 32 bits.
- R3: At offset 0x10, select 0x00 is the ID register. A read returns the ID in bits 31:24 with all other bits zero. A write loads the ID from wdata[31:24].
- R4: At offset 0x10, select 0x01 reads 0x00170011. This word carries version 0x11 in bits 7:0 and the highest entry index, NUM_ENTRIES-1 = 23, in bits 23:16. Writes to it change nothing.
- R5: At offset 0x10, select 0x02 reads zero and ignores writes. Selects 0x03 to 0x0F also read zero and ignore writes.
- R6: A select s of 0x10 or more addresses entry (s-0x10)/2. An even s reaches entry bits 31:0 and an odd s reaches entry bits 63:32. A write to one half leaves the other half unchanged.
- R7: A select whose entry index is 24 or more (select 0x40 to 0xFF) reads zero. A write to it changes no entry and produces no strobe.
- R8: A write to any entry half raises svc_pulse_o for exactly the one cycle after the write edge. At no other time is svc_pulse_o high.
- R9: After reset, every entry holds 0x0000_0000_0001_0000 (masked, all other fields zero). The select register and the ID are zero, and svc_pulse_o is low.
- R10: entries_o carries entry i on bits 64*i+63 to 64*i. It shows the new value from the write edge onward.
- R11: Offsets other than 0x00 and 0x10 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 12 | Byte offset into the window; only bits 7:0 are decoded |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| entries_o | output | 1536 | All redirection entries side by side, entry 0 in the low bits |
| svc_pulse_o | output | 1 | One-cycle strobe after any entry write |

## Verification
The case that is hardest to reach from the ports is a write that falls outside the table: an index past the last entry, a reserved select, or a stray offset. Such a write must leave all 1536 stored bits alone, and the ports give no direct sign that it did. The bench keeps its own copy of the whole table, built from the requirements, and compares the full entries_o bus against it after every such write. The same checks cover aliased high address bits and the two halves of the very last entry, at selects 0x3E and 0x3F. Strobe timing is sampled on the falling edge that follows each write edge.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;

    localparam int unsigned BUS_W   = 32;
    localparam int unsigned SEL_W   = 8;
    localparam int unsigned ENTRY_W = 64;

    localparam logic [7:0] OFF_SELECT = 8'h00;
    localparam logic [7:0] OFF_WINDOW = 8'h10;

    localparam logic [SEL_W-1:0] SEL_IDENT = 8'h00;
    localparam logic [SEL_W-1:0] SEL_VERS  = 8'h01;
    localparam logic [SEL_W-1:0] SEL_ARB   = 8'h02;
    localparam logic [SEL_W-1:0] SEL_TABLE = 8'h10;

    localparam logic [7:0] VERSION_CODE = 8'h11;

    // masked bit set, every other field clear
    localparam logic [ENTRY_W-1:0] ENTRY_RESET = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        K_IDENT,
        K_VERS,
        K_ZERO,
        K_ENTRY,
        K_NONE
    } sel_kind_e;

    typedef struct packed {
        logic [BUS_W-1:0] hi;
        logic [BUS_W-1:0] lo;
    } entry_t;

    function automatic logic [BUS_W-1:0] version_word(input int unsigned n);
        return {8'h00, 8'(n - 1), 8'h00, VERSION_CODE};
    endfunction

endpackage

// File: rtl/ioredir_decode.sv
module ioredir_decode
    import ioredir_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 24,
    parameter int unsigned ADDR_W      = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   wr_i,
    input  logic [BUS_W-1:0]       wdata_i,
    output logic [SEL_W-1:0]       sel_o,
    output logic                   at_select_o,
    output logic                   at_window_o,
    output sel_kind_e              kind_o,
    output logic [SEL_W-2:0]       index_o,
    output logic                   upper_o,
    output logic                   ident_we_o,
    output logic [NUM_ENTRIES-1:0] we_lo_o,
    output logic [NUM_ENTRIES-1:0] we_hi_o
);
    localparam int unsigned IDX_W = SEL_W - 1;

    logic [SEL_W-1:0] sel_q;
    logic [SEL_W-1:0] rel;
    logic [7:0]       off;
    logic             in_table;
    logic             win_wr;

    assign off         = addr_i[7:0];
    assign at_select_o = (off == OFF_SELECT);
    assign at_window_o = (off == OFF_WINDOW);

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (wr_i && at_select_o)
            sel_q <= wdata_i[SEL_W-1:0];
    end

    assign rel      = sel_q - SEL_TABLE;
    assign index_o  = rel[SEL_W-1:1];
    assign upper_o  = rel[0];
    assign in_table = (sel_q >= SEL_TABLE) && (32'(index_o) < NUM_ENTRIES);

    always_comb begin
        if (sel_q == SEL_IDENT)     kind_o = K_IDENT;
        else if (sel_q == SEL_VERS) kind_o = K_VERS;
        else if (sel_q == SEL_ARB)  kind_o = K_ZERO;
        else if (in_table)          kind_o = K_ENTRY;
        else                        kind_o = K_NONE;
    end

    assign sel_o      = sel_q;
    assign win_wr     = wr_i && at_window_o;
    assign ident_we_o = win_wr && (kind_o == K_IDENT);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_we
        assign we_lo_o[i] = win_wr && (kind_o == K_ENTRY) && (32'(index_o) == i) && !upper_o;
        assign we_hi_o[i] = win_wr && (kind_o == K_ENTRY) && (32'(index_o) == i) &&  upper_o;
    end

    // R7: at most one half of one entry is written per cycle
    a_r7_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({we_lo_o, we_hi_o}));

    // R5: reserved selects never write any entry
    a_r5_reserved_no_write: assert property (@(posedge clk) disable iff (rst)
        (sel_q < SEL_TABLE) |-> (we_lo_o == '0 && we_hi_o == '0));

    logic [IDX_W-1:0] unused_idx;
    assign unused_idx = '0;
endmodule

// File: rtl/ioredir_entry.sv
module ioredir_entry
    import ioredir_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_lo_i,
    input  logic             we_hi_i,
    input  logic [BUS_W-1:0] wdata_i,
    output entry_t           entry_o
);
    entry_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= entry_t'(ENTRY_RESET);
        end else begin
            if (we_lo_i) q.lo <= wdata_i;
            if (we_hi_i) q.hi <= wdata_i;
        end
    end

    assign entry_o = q;

    // R6: the untouched half keeps its value
    a_r6_hi_kept: assert property (@(posedge clk) disable iff (rst)
        (we_lo_i && !we_hi_i) |=> $stable(q.hi));
    a_r6_lo_kept: assert property (@(posedge clk) disable iff (rst)
        (we_hi_i && !we_lo_i) |=> $stable(q.lo));
    // R7: without a strobe the entry holds
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!we_lo_i && !we_hi_i) |=> $stable(q));
endmodule

// File: rtl/ioredir_regfile.sv
module ioredir_regfile
    import ioredir_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 24,
    parameter int unsigned ADDR_W      = 12
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [ADDR_W-1:0]              bus_addr_i,
    input  logic                           bus_wr_i,
    input  logic [BUS_W-1:0]               bus_wdata_i,
    output logic [BUS_W-1:0]               bus_rdata_o,
    output logic [NUM_ENTRIES*ENTRY_W-1:0] entries_o,
    output logic                           svc_pulse_o
);
    localparam logic [BUS_W-1:0] VERS_WORD = version_word(NUM_ENTRIES);

    logic [SEL_W-1:0]       sel;
    logic                   at_select, at_window;
    sel_kind_e              kind;
    logic [SEL_W-2:0]       index;
    logic                   upper;
    logic                   ident_we;
    logic [NUM_ENTRIES-1:0] we_lo, we_hi;
    entry_t                 table_q [NUM_ENTRIES];
    logic [7:0]             ident_q;
    logic                   pulse_q;
    logic [BUS_W-1:0]       half_rd;
    logic [BUS_W-1:0]       win_rd;

    ioredir_decode #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_decode (
        .clk         (clk),
        .rst         (rst),
        .addr_i      (bus_addr_i),
        .wr_i        (bus_wr_i),
        .wdata_i     (bus_wdata_i),
        .sel_o       (sel),
        .at_select_o (at_select),
        .at_window_o (at_window),
        .kind_o      (kind),
        .index_o     (index),
        .upper_o     (upper),
        .ident_we_o  (ident_we),
        .we_lo_o     (we_lo),
        .we_hi_o     (we_hi)
    );

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
        ioredir_entry u_entry (
            .clk     (clk),
            .rst     (rst),
            .we_lo_i (we_lo[i]),
            .we_hi_i (we_hi[i]),
            .wdata_i (bus_wdata_i),
            .entry_o (table_q[i])
        );
        assign entries_o[i*ENTRY_W +: ENTRY_W] = table_q[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ident_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            if (ident_we) ident_q <= bus_wdata_i[31:24];
            pulse_q <= |{we_lo, we_hi};
        end
    end

    assign svc_pulse_o = pulse_q;

    always_comb begin
        half_rd = '0;
        for (int i = 0; i < NUM_ENTRIES; i++)
            if (32'(index) == i)
                half_rd = upper ? table_q[i].hi : table_q[i].lo;
    end

    always_comb begin
        unique case (kind)
            K_IDENT: win_rd = {ident_q, 24'h0};
            K_VERS:  win_rd = VERS_WORD;
            K_ENTRY: win_rd = half_rd;
            default: win_rd = '0;
        endcase
    end

    always_comb begin
        if (at_select)      bus_rdata_o = {{(BUS_W-SEL_W){1'b0}}, sel};
        else if (at_window) bus_rdata_o = win_rd;
        else                bus_rdata_o = '0;
    end

    // R8: a strobe only ever follows an entry write
    a_r8_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        svc_pulse_o |-> $past(|{we_lo, we_hi}));
    a_r8_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
        (|{we_lo, we_hi}) |=> svc_pulse_o);
    // R4: the version word is constant and ignores writes
    a_r4_version_fixed: assert property (@(posedge clk) disable iff (rst)
        (at_window && sel == SEL_VERS) |-> (bus_rdata_o == VERS_WORD));
    // R3: the ID changes only through a window write at select zero
    a_r3_ident_guard: assert property (@(posedge clk) disable iff (rst)
        !ident_we |=> $stable(ident_q));
endmodule

// File: tb/ioredir_regfile_test.sv
`timescale 1ns/1ps
module ioredir_regfile_test;
    localparam int N = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [11:0]       addr = '0;
    logic              wr = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic [N*64-1:0]   ents;
    logic              pulse;

    int checks = 0;
    int errors = 0;
    logic [63:0] model [N];
    logic last_pulse;

    always #2.5 clk = ~clk;

    ioredir_regfile uut (
        .clk(clk), .rst(rst), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .entries_o(ents),
        .svc_pulse_o(pulse)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_table(input string req);
        logic [N*64-1:0] exp;
        for (int i = 0; i < N; i++) exp[i*64 +: 64] = model[i];
        checks++;
        if (ents !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, ents, exp);
        end
    endtask

    // drive at negedge, the write lands at the next posedge, sample at the following negedge
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        last_pulse = pulse;
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; wr = 1'b0;
        #1 d = rdata;
    endtask

    task automatic sel_set(input logic [7:0] s);
        bus_write(12'h000, {24'h0, s});
    endtask

    task automatic t_reset;
        logic [31:0] v;
        bus_read(12'h000, v); check32("R9 select after reset", v, 32'h0);
        bus_read(12'h010, v); check32("R9 ID after reset", v, 32'h0);
        check32("R9 pulse after reset", {31'h0, pulse}, 32'h0);
        check_table("R9 entries after reset");
        sel_set(8'h10); bus_read(12'h010, v); check32("R9 entry0 low", v, 32'h0001_0000);
        sel_set(8'h11); bus_read(12'h010, v); check32("R9 entry0 high", v, 32'h0);
    endtask

    task automatic t_select_and_ident;
        logic [31:0] v;
        bus_write(12'h000, 32'hFFFF_FF5A);
        bus_read(12'h000, v); check32("R2 select zero-extended", v, 32'h0000_005A);
        sel_set(8'h00);
        bus_write(12'h010, 32'hAB12_3456);
        check32("R3 ID write gives no pulse", {31'h0, last_pulse}, 32'h0);
        bus_read(12'h010, v); check32("R3 ID readback", v, 32'hAB00_0000);
        check_table("R3 ID write leaves entries");
    endtask

    task automatic t_fixed_words;
        logic [31:0] v;
        sel_set(8'h01);
        bus_write(12'h010, 32'hFFFF_FFFF);
        bus_read(12'h010, v); check32("R4 version word", v, 32'h0017_0011);
        sel_set(8'h02);
        bus_write(12'h010, 32'hFFFF_FFFF);
        bus_read(12'h010, v); check32("R5 arbitration zero", v, 32'h0);
        for (int s = 3; s < 16; s++) begin
            sel_set(8'(s));
            bus_write(12'h010, 32'hDEAD_BEEF);
            check32("R5 reserved no pulse", {31'h0, last_pulse}, 32'h0);
            bus_read(12'h010, v); check32("R5 reserved select zero", v, 32'h0);
        end
        check_table("R5 entries untouched");
        sel_set(8'h00); bus_read(12'h010, v); check32("R3 ID survives", v, 32'hAB00_0000);
    endtask

    task automatic t_entries;
        logic [31:0] v;
        sel_set(8'h14);                       // entry 2 low
        bus_write(12'h010, 32'h0000_A031);
        model[2][31:0] = 32'h0000_A031;
        check32("R8 pulse after low write", {31'h0, last_pulse}, 32'h1);
        check_table("R10 entry 2 low visible");
        @(negedge clk); check32("R8 pulse one cycle only", {31'h0, pulse}, 32'h0);
        sel_set(8'h15);                       // entry 2 high
        bus_write(12'h010, 32'h7700_0000);
        model[2][63:32] = 32'h7700_0000;
        check32("R8 pulse after high write", {31'h0, last_pulse}, 32'h1);
        check_table("R6 low half kept on high write");
        bus_read(12'h010, v); check32("R6 odd select reads high", v, 32'h7700_0000);
        sel_set(8'h14); bus_read(12'h010, v); check32("R6 even select reads low", v, 32'h0000_A031);
        sel_set(8'h3E); bus_write(12'h010, 32'h1234_5678); model[23][31:0] = 32'h1234_5678;
        sel_set(8'h3F); bus_write(12'h010, 32'h9ABC_DEF0); model[23][63:32] = 32'h9ABC_DEF0;
        check_table("R10 last entry placement");
        bus_read(12'h010, v); check32("R6 last entry high", v, 32'h9ABC_DEF0);
    endtask

    task automatic t_out_of_range;
        logic [31:0] v;
        for (int s = 8'h40; s <= 8'hFF; s += 8'h3F) begin
            sel_set(8'(s));
            bus_write(12'h010, 32'hFFFF_FFFF);
            check32("R7 no pulse past table", {31'h0, last_pulse}, 32'h0);
            bus_read(12'h010, v); check32("R7 reads zero past table", v, 32'h0);
            check_table("R7 entries unchanged");
        end
    endtask

    task automatic t_offsets;
        logic [31:0] v;
        sel_set(8'h12);
        bus_write(12'h004, 32'h5555_5555);
        bus_write(12'h014, 32'h6666_6666);
        bus_write(12'h0FF, 32'h7777_7777);
        check32("R11 stray offset no pulse", {31'h0, last_pulse}, 32'h0);
        bus_read(12'h020, v); check32("R11 stray offset reads zero", v, 32'h0);
        bus_read(12'h000, v); check32("R11 select unchanged", v, 32'h12);
        check_table("R11 entries unchanged");
        bus_write(12'h310, 32'hCAFE_0042);    // aliases the window
        model[1][31:0] = 32'hCAFE_0042;
        check32("R1 alias write pulses", {31'h0, last_pulse}, 32'h1);
        check_table("R1 alias write lands");
        bus_write(12'hA00, 32'h0000_0013);    // aliases the select
        bus_read(12'h700, v); check32("R1 alias select", v, 32'h13);
        bus_read(12'hF10, v); check32("R1 alias window read", v, 32'h0);
        sel_set(8'h12); bus_read(12'h510, v); check32("R1 alias read entry", v, 32'hCAFE_0042);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) model[i] = 64'h0000_0000_0001_0000;
        last_pulse = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_select_and_ident();
        t_fixed_words();
        t_entries();
        t_out_of_range();
        t_offsets();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule